// File: doc/BRIEF.md
# Dual Prescaled Timer/Counter with Overflow Interrupts

This block holds two independent timer/counter channels for a small microcontroller core. Each channel either counts machine cycles or counts falling edges on its own external pin. A machine cycle is twelve core clocks. A channel works in one of two modes:

- **Wide mode:** a single 16-bit counter.
- **Reload mode:** an 8-bit counter whose low byte refills from the high byte whenever it rolls over.

Every rollover sets a sticky per-channel flag, and that flag drives the channel's interrupt request.

The processor reaches the four count bytes through a small register port. The read data follows the address in the same cycle. A write takes effect at the next clock edge, and it wins over any count in that cycle. A flag is cleared by a processor clear strobe or by the interrupt acknowledge for its channel. Every pin of the block is a plain level or strobe. The register port moves single bytes on demand, so there is no streaming traffic and no back-pressure to manage.

Top module: `dtmr_pair`

## Requirements
- R1: With `run` high and `src_sel`=0 (machine-cycle source), a channel advances by exactly N over any 12*N consecutive clock cycles of running.
- R2: With `src_sel`=1 (pin source), each high-to-low transition on `ext_pin` advances the channel by one. Rising transitions and elapsed machine cycles cause no advance. The new count is readable in the cycle after the third rising clock edge that follows the pin change.
- R3: While `run` is low, a channel's count bytes do not change except by register writes.
- R4: With `mode_sel`=1 (wide mode), the count is the 16-bit value {high,low}; a carry passes from the low byte into the high byte. Advancing from 0xFFFF gives 0x0000 and sets the channel flag.
- R5: With `mode_sel`=0 (reload mode), only the low byte advances. Advancing from 0xFF loads the low byte with the high byte, leaves the high byte unchanged, and sets the channel flag.
- R6: `irq` of a channel equals its flag. The flag stays set until a `flag_clr` or `irq_ack` pulse for that channel, and it reads 0 in the cycle after that pulse.
- R7: `reg_addr` bit 0 selects the high byte (1) or the low byte (0), and the bits above it select the channel. `reg_rdata` shows the selected byte in the same cycle. A write with `reg_wr` is readable after the next rising edge.
- R8: A write to either byte of a channel in a cycle where that channel would advance cancels that advance. The written value is stored exactly.
- R9: The channels are independent: counting, overflow and clearing in one channel leave the other's bytes and `irq` unchanged.
- R10: After reset, all count bytes are 0 and both `irq` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 2 | Per-channel count enable |
| src_sel | input | 2 | Per-channel count source: 0 machine cycle, 1 external pin |
| mode_sel | input | 2 | Per-channel mode: 0 8-bit reload, 1 16-bit |
| ext_pin | input | 2 | Per-channel external count input (asynchronous) |
| reg_addr | input | 2 | Byte select: {channel, high/low} |
| reg_wr | input | 1 | Write strobe for the addressed byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed byte |
| flag_clr | input | 2 | Per-channel processor clear of the overflow flag |
| irq_ack | input | 2 | Per-channel interrupt acknowledge, also clears the flag |
| irq | output | 2 | Per-channel interrupt request |

## Verification
Each result arrives at a known delay after its stimulus:

- **Register reads** are combinational, so the bench samples them shortly after it drives the address.
- **Writes and clears** appear one edge after their strobe.
- **Machine-cycle counting** is checked without depending on the divider's phase: `run` is held for exactly 12*N edges and the bench then expects exactly N advances.
- **Pin edges** are held for three clock edges before the count is sampled.

To check write priority, the bench drives a register write into the precise cycle in which a pin edge's advance is due.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  typedef enum logic {CSRC_MCYC = 1'b0, CSRC_PIN = 1'b1} csrc_e;
  typedef enum logic {CMODE_RELOAD8 = 1'b0, CMODE_WIDE16 = 1'b1} cmode_e;
endpackage

// File: rtl/dtmr_mcyc.sv
module dtmr_mcyc #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (tick)   phase_q <= '0;
    else             phase_q <= phase_q + PW'(1);
  end

  // R1: one tick per machine cycle, never two back to back
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);
endmodule

// File: rtl/dtmr_fall.sv
module dtmr_fall #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [SYNC:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[SYNC-1:0], pin};
  end

  assign fall = sh_q[SYNC] & ~sh_q[SYNC-1];

  // R2: a single pin transition yields a one-cycle count pulse
  a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmode_e        mode,
  input  logic          inc,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  input  logic          clr,
  output logic [BW-1:0] cnt_lo,
  output logic [BW-1:0] cnt_hi,
  output logic          flag
);
  localparam int FW = 2 * BW;

  logic [FW-1:0] full, full_inc;
  logic [BW-1:0] lo_nxt, hi_nxt;
  logic          ovf;

  assign full     = {cnt_hi, cnt_lo};
  assign full_inc = full + FW'(1);

  always_comb begin
    lo_nxt = cnt_lo;
    hi_nxt = cnt_hi;
    ovf    = 1'b0;
    if (wr_lo || wr_hi) begin
      if (wr_lo) lo_nxt = wdata;
      if (wr_hi) hi_nxt = wdata;
    end else if (inc) begin
      if (mode == CMODE_WIDE16) begin
        {hi_nxt, lo_nxt} = full_inc;
        ovf = &full;
      end else if (&cnt_lo) begin
        lo_nxt = cnt_hi;
        ovf    = 1'b1;
      end else begin
        lo_nxt = cnt_lo + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      flag   <= 1'b0;
    end else begin
      cnt_lo <= lo_nxt;
      cnt_hi <= hi_nxt;
      if (ovf)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R3: no advance and no write leaves the bytes alone
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_lo && !wr_hi) |=> $stable(cnt_lo) && $stable(cnt_hi));
  // R4: wide rollover wraps to zero and raises the flag
  a_r4_wrap16: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_lo && !wr_hi && mode == CMODE_WIDE16 && &cnt_hi && &cnt_lo)
    |=> (cnt_hi == '0) && (cnt_lo == '0) && flag);
  // R5: reload from high byte on 8-bit rollover
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_lo && !wr_hi && mode == CMODE_RELOAD8 && &cnt_lo)
    |=> (cnt_lo == $past(cnt_hi)) && $stable(cnt_hi) && flag);
  // R6: flag is sticky without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R8: written byte is stored exactly, even against an advance
  a_r8_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_lo == $past(wdata));
endmodule

// File: rtl/dtmr_pair.sv
module dtmr_pair
  import dtmr_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int BW   = 8,
  parameter int DIV  = 12,
  parameter int SYNC = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] run,
  input  logic [NCH-1:0] src_sel,
  input  logic [NCH-1:0] mode_sel,
  input  logic [NCH-1:0] ext_pin,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_wr,
  input  logic [BW-1:0]  reg_wdata,
  output logic [BW-1:0]  reg_rdata,
  input  logic [NCH-1:0] flag_clr,
  input  logic [NCH-1:0] irq_ack,
  output logic [NCH-1:0] irq
);
  logic           mc_tick;
  logic [NCH-1:0] pin_fall;
  logic [NCH-1:0] adv;
  logic [BW-1:0]  lo_q [NCH];
  logic [BW-1:0]  hi_q [NCH];
  logic [CHW-1:0] sel_ch;
  logic           sel_hi;

  assign sel_ch = reg_addr[AW-1:1];
  assign sel_hi = reg_addr[0];

  dtmr_mcyc #(.DIV(DIV)) u_mcyc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (mc_tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic   hit;
    csrc_e  src;

    assign hit = reg_wr && (sel_ch == CHW'(g));
    assign src = csrc_e'(src_sel[g]);
    assign adv[g] = run[g] && ((src == CSRC_PIN) ? pin_fall[g] : mc_tick);

    dtmr_fall #(.SYNC(SYNC)) u_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin[g]),
      .fall  (pin_fall[g])
    );

    dtmr_chan #(.BW(BW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (cmode_e'(mode_sel[g])),
      .inc    (adv[g]),
      .wr_lo  (hit && !sel_hi),
      .wr_hi  (hit && sel_hi),
      .wdata  (reg_wdata),
      .clr    (flag_clr[g] || irq_ack[g]),
      .cnt_lo (lo_q[g]),
      .cnt_hi (hi_q[g]),
      .flag   (irq[g])
    );

    // R9: a channel that neither advances nor is written keeps its bytes
    a_r9_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv[g] && !hit) |=> $stable(lo_q[g]) && $stable(hi_q[g]));
    // R2: pin edges are ignored in machine-cycle mode
    a_r2_src_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (src == CSRC_MCYC && !mc_tick) |-> !adv[g]);
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (sel_ch == CHW'(c)) reg_rdata = sel_hi ? hi_q[c] : lo_q[c];
    end
  end

  // R10: reset leaves no interrupt pending
  a_r10_reset_irq: assert property (@(posedge clk)
    !rst_n |-> irq == '0);
endmodule

// File: tb/sim_dtmr_pair.sv
module sim_dtmr_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] run = '0, src_sel = '0, mode_sel = '0, ext_pin = '1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] flag_clr = '0, irq_ack = '0, irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dtmr_pair u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel),
    .mode_sel(mode_sel), .ext_pin(ext_pin), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flag_clr(flag_clr), .irq_ack(irq_ack), .irq(irq)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(int ch, int hi, int val);
    @(negedge clk);
    reg_addr = 2'(ch * 2 + hi); reg_wdata = 8'(val); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_byte(int ch, int hi, output int val);
    reg_addr = 2'(ch * 2 + hi);
    #1 val = int'(reg_rdata);
  endtask

  task automatic rd16(int ch, output int val);
    int h, l;
    rd_byte(ch, 1, h); rd_byte(ch, 0, l);
    val = h * 256 + l;
  endtask

  task automatic pulse(int ch);
    @(negedge clk); ext_pin[ch] = 1'b0;
    repeat (3) @(negedge clk);
    ext_pin[ch] = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear(int ch);
    @(negedge clk); flag_clr[ch] = 1'b1;
    @(negedge clk); flag_clr[ch] = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, h, l, ef, exp16, eh, el;
    int hv[3] = '{8'h00, 8'h5A, 8'hFE};
    int lv[2] = '{8'hFD, 8'hFF};
    int sv[4] = '{16'hFFFE, 16'h12FF, 16'h00FF, 16'hFFFF};

    repeat (3) @(negedge clk);
    // R10: reset state
    for (int c = 0; c < 2; c++) begin
      rd_byte(c, 0, v); chk("R10 lo", v, 0);
      rd_byte(c, 1, v); chk("R10 hi", v, 0);
    end
    chk("R10 irq", int'(irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: write and read back every byte
    wr_byte(0, 0, 8'h11); wr_byte(0, 1, 8'h22);
    wr_byte(1, 0, 8'h33); wr_byte(1, 1, 8'h44);
    rd_byte(0, 0, v); chk("R7 c0 lo", v, 8'h11);
    rd_byte(0, 1, v); chk("R7 c0 hi", v, 8'h22);
    rd_byte(1, 0, v); chk("R7 c1 lo", v, 8'h33);
    rd_byte(1, 1, v); chk("R7 c1 hi", v, 8'h44);

    // R1: machine-cycle counting, N advances per 12*N cycles
    mode_sel = 2'b01; src_sel = 2'b00;
    for (int n = 1; n <= 6; n++) begin
      wr_byte(0, 0, 0); wr_byte(0, 1, 0);
      @(negedge clk); run[0] = 1'b1;
      repeat (12 * n) @(negedge clk);
      run[0] = 1'b0;
      rd16(0, v); chk("R1 mcyc count", v, n);
    end

    // R3: stopped channel holds
    rd16(0, h);
    repeat (40) @(negedge clk);
    src_sel[0] = 1'b1; pulse(0); pulse(0);
    rd16(0, v); chk("R3 hold while stopped", v, h);

    // R2: pin mode ignores machine cycles, counts falling edges only
    run[0] = 1'b1;
    repeat (50) @(negedge clk);
    rd16(0, v); chk("R2 no mcyc in pin mode", v, h);
    pulse(0); pulse(0); pulse(0);
    rd16(0, v); chk("R2 three falls", v, h + 3);
    @(negedge clk); ext_pin[0] = 1'b0;
    repeat (5) @(negedge clk);
    rd16(0, v); chk("R2 fall counted", v, h + 4);
    ext_pin[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd16(0, v); chk("R2 rise ignored", v, h + 4);

    // R4: 16-bit sweep with carry and wrap
    foreach (sv[i]) begin
      for (int n = 1; n <= 3; n++) begin
        wr_byte(0, 1, sv[i] / 256); wr_byte(0, 0, sv[i] % 256);
        clear(0);
        for (int k = 0; k < n; k++) pulse(0);
        exp16 = (sv[i] + n) % 65536;
        ef = (sv[i] + n > 65535) ? 1 : 0;
        rd16(0, v); chk("R4 wide count", v, exp16);
        chk("R4 wide flag", int'(irq[0]), ef);
      end
    end

    // R5: 8-bit reload sweep
    mode_sel[0] = 1'b0;
    foreach (hv[a]) foreach (lv[b]) begin
      for (int n = 1; n <= 4; n += 3) begin
        wr_byte(0, 1, hv[a]); wr_byte(0, 0, lv[b]);
        clear(0);
        el = lv[b]; ef = 0;
        for (int k = 0; k < n; k++) begin
          pulse(0);
          if (el == 255) begin el = hv[a]; ef = 1; end else el++;
        end
        rd_byte(0, 0, v); chk("R5 reload lo", v, el);
        rd_byte(0, 1, v); chk("R5 hi kept", v, hv[a]);
        chk("R5 flag", int'(irq[0]), ef);
      end
    end

    // R6: flag sticky, cleared by clear strobe and by acknowledge
    wr_byte(0, 1, 8'h10); wr_byte(0, 0, 8'hFF);
    pulse(0);
    repeat (20) @(negedge clk);
    #1 chk("R6 flag sticky", int'(irq[0]), 1);
    @(negedge clk); irq_ack[0] = 1'b1;
    @(negedge clk); irq_ack[0] = 1'b0;
    #1 chk("R6 ack clears", int'(irq[0]), 0);
    wr_byte(0, 0, 8'hFF); pulse(0);
    #1 chk("R6 set again", int'(irq[0]), 1);
    clear(0);
    #1 chk("R6 clr clears", int'(irq[0]), 0);

    // R8: write lands in the advance cycle of a pin edge
    wr_byte(0, 0, 8'h20); wr_byte(0, 1, 8'h07);
    @(negedge clk); ext_pin[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 2'b00; reg_wdata = 8'h55; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    ext_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd_byte(0, 0, v); chk("R8 write wins lo", v, 8'h55);
    rd_byte(0, 1, v); chk("R8 hi untouched", v, 8'h07);

    // R9: channel 1 counts and overflows, channel 0 stays
    rd16(0, h);
    run = 2'b11; src_sel = 2'b11; mode_sel = 2'b10;
    wr_byte(1, 1, 8'hFF); wr_byte(1, 0, 8'hFE);
    clear(1);
    pulse(1); pulse(1); pulse(1);
    rd16(1, v); chk("R9 c1 count", v, 1);
    chk("R9 c1 irq", int'(irq[1]), 1);
    rd16(0, v); chk("R9 c0 unchanged", v, h);
    chk("R9 c0 irq", int'(irq[0]), 0);
    eh = 0;
    clear(1);
    #1 chk("R9 c1 cleared", int'(irq[1]), eh);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule